// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the operating mode of a small microcontroller among five modes: full-speed run, wait, stop, very-low-power run and very-low-power wait. The core reports a stop instruction as a single-cycle pulse. Device-level inputs decide which low-power mode that pulse selects: the requested sleep depth in full run, and the wait-only path in very-low-power run. Qualified interrupts, a synchronous system reset and a wake-on-interrupt configuration bit move the device back out of these modes.

The controller drives four registered outputs. A 3-bit mode status lets software poll until full run is reached before it raises the clock frequency. Per-peripheral clock enables follow a software gating mask, and in stop only the always-on clocks stay enabled. A regulator-mode signal selects reduced regulation. A debug-allowed flag reports whether debug access is available.

The analog regulator, the clock generator and the interrupt stacking are not part of the block. Only the control levels they would consume are produced here. Leaving very-low-power wait or very-low-power run for full run takes two steps. The regulator is switched back to full regulation on one edge, and the status reports run on the following edge.

Top module: `lpmc_top`

## Requirements
- R1: `mode_status` always holds one of the encodings run=0, wait=1, stop=2, very-low-power run=3, very-low-power wait=4, and it changes on the same rising edge that commits a transition.
- R2: In run, a stop pulse with `deep_sleep`=0 enters wait, and with `deep_sleep`=1 enters stop, at the sampling edge.
- R3: `periph_clk_en` equals `gate_mask` in every mode except stop, where it equals `gate_mask & ALWAYS_ON` (default `ALWAYS_ON` = 8'h01). It updates on the same edge as `mode_status`.
- R4: An interrupt counts only if the same bit is set in both `irq_pending` and `irq_enable`. A counted interrupt in wait or stop returns to run at the next edge, and a pending but disabled interrupt leaves the mode unchanged.
- R5: A stop pulse in the same cycle as a counted interrupt is ignored, and the device stays in its current run mode.
- R6: In run, with no stop pulse, `vlp_request`=1 enters very-low-power run, and `reg_low`=1 from that edge on.
- R7: In very-low-power run, a stop pulse with `deep_sleep`=0 enters very-low-power wait with `reg_low` held at 1. A stop pulse with `deep_sleep`=1 is ignored.
- R8: In very-low-power wait with `wake_full`=1, a counted interrupt drops `reg_low` to 0 at the next edge while the status still reads 4. The status reads 0 one edge later.
- R9: In very-low-power wait with `wake_full`=0, a counted interrupt returns the device to very-low-power run (status 3) at the next edge, and `reg_low` stays 1.
- R10: In very-low-power run with `vlp_request`=0, the device returns to run with the same two-step order as R8: `reg_low` goes to 0 first while the status still reads 3.
- R11: A synchronous `rst` from any mode sets, at the next edge, status 0, `periph_clk_en`=0, `reg_low`=0 and `dbg_allowed`=0.
- R12: `dbg_allowed` is `!secured & dbg_enable` in run and very-low-power run, and 0 in stop. In wait and very-low-power wait it is 1 only if `dbg_arm`, `!secured` and `dbg_enable` were all true at the entry edge and `!secured & dbg_enable` still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| stop_pulse | input | 1 | Single-cycle pulse from the core: a stop instruction executed |
| deep_sleep | input | 1 | Requested sleep depth in run: 1 selects stop, 0 selects wait |
| vlp_request | input | 1 | Level request to be in very-low-power run |
| wake_full | input | 1 | Wake target from very-low-power wait: 1 full run, 0 very-low-power run |
| irq_pending | input | NUM_IRQ | Pending interrupt lines |
| irq_enable | input | NUM_IRQ | Interrupt enable mask |
| gate_mask | input | NUM_PERIPH | Software per-peripheral clock gating bits |
| secured | input | 1 | Device security active |
| dbg_enable | input | 1 | Debug mode enabled |
| dbg_arm | input | 1 | Debug-enable bit that must be set before entering a wait mode |
| mode_status | output | 3 | Current mode encoding |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| reg_low | output | 1 | 1 selects reduced (stop) regulation |
| dbg_allowed | output | 1 | Debug access is available |

## Verification
The assertions treat `stop_pulse`, the interrupt lines and the configuration inputs as synchronous levels that are stable around each rising edge. They also treat a counted interrupt as a plain level, with no edge detection. The bench changes every input only on the falling edge. It raises `stop_pulse` for one cycle at a time and holds or clears interrupt levels explicitly, so that each input reaches the design as the assertions take it. Randomised phases draw from the same discipline and apply reset only occasionally, so that long mode sequences are covered.

// File: rtl/lpmc_pkg.sv
package lpmc_pkg;

  typedef enum logic [2:0] {
    MD_RUN  = 3'd0,
    MD_WAIT = 3'd1,
    MD_STOP = 3'd2,
    MD_VLPR = 3'd3,
    MD_VLPW = 3'd4
  } mode_e;

  function automatic logic is_low_reg(input mode_e m);
    return (m == MD_VLPR) || (m == MD_VLPW);
  endfunction

  function automatic logic is_wait(input mode_e m);
    return (m == MD_WAIT) || (m == MD_VLPW);
  endfunction

endpackage

// File: rtl/lpmc_wake.sv
module lpmc_wake #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  output logic               wake
);

  logic [NUM_IRQ-1:0] qual;

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_qual
      assign qual[i] = irq_pending[i] & irq_enable[i];
    end
  endgenerate

  assign wake = |qual;

endmodule

// File: rtl/lpmc_fsm.sv
module lpmc_fsm
  import lpmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  stop_pulse,
  input  logic  deep_sleep,
  input  logic  vlp_request,
  input  logic  wake_full,
  input  logic  wake,
  input  logic  secured,
  input  logic  dbg_enable,
  input  logic  dbg_arm,
  output mode_e nxt_mode,
  output logic  nxt_exit,
  output logic  nxt_arm
);

  mode_e cur_mode;
  logic  exit_q;
  logic  arm_q;
  logic  stop_ok;
  logic  arm_now;

  assign stop_ok = stop_pulse & ~wake;
  assign arm_now = ~secured & dbg_enable & dbg_arm;

  always_comb begin
    nxt_mode = cur_mode;
    nxt_exit = 1'b0;
    nxt_arm  = arm_q;
    if (exit_q) begin
      nxt_mode = MD_RUN;
    end else begin
      unique case (cur_mode)
        MD_RUN: begin
          if (stop_ok) begin
            nxt_mode = deep_sleep ? MD_STOP : MD_WAIT;
            nxt_arm  = arm_now;
          end else if (vlp_request && !stop_pulse) begin
            nxt_mode = MD_VLPR;
          end
        end
        MD_VLPR: begin
          if (stop_ok && !deep_sleep) begin
            nxt_mode = MD_VLPW;
            nxt_arm  = arm_now;
          end else if (!stop_pulse && !vlp_request) begin
            nxt_exit = 1'b1;
          end
        end
        MD_WAIT, MD_STOP: begin
          if (wake) nxt_mode = MD_RUN;
        end
        MD_VLPW: begin
          if (wake) begin
            if (wake_full) nxt_exit = 1'b1;
            else           nxt_mode = MD_VLPR;
          end
        end
        default: nxt_mode = MD_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode <= MD_RUN;
      exit_q   <= 1'b0;
      arm_q    <= 1'b0;
    end else begin
      cur_mode <= nxt_mode;
      exit_q   <= nxt_exit;
      arm_q    <= nxt_arm;
    end
  end

  AST_STOP_WAKE_CLASH: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MD_RUN && !exit_q && stop_pulse && wake) |=> (cur_mode == MD_RUN)); // R5
  AST_WAIT_WAKE: assert property (@(posedge clk) disable iff (rst)
    ((cur_mode == MD_WAIT || cur_mode == MD_STOP) && wake) |=> (cur_mode == MD_RUN)); // R4
  AST_VLPW_DEEP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MD_VLPR && !exit_q && stop_pulse && deep_sleep) |=> (cur_mode == MD_VLPR)); // R7

endmodule

// File: rtl/lpmc_outreg.sv
module lpmc_outreg
  import lpmc_pkg::*;
#(
  parameter int                 NUM_PERIPH = 8,
  parameter logic [NUM_PERIPH-1:0] ALWAYS_ON = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  mode_e                 nxt_mode,
  input  logic                  nxt_exit,
  input  logic                  nxt_arm,
  input  logic [NUM_PERIPH-1:0] gate_mask,
  input  logic                  secured,
  input  logic                  dbg_enable,
  output logic [2:0]            mode_status,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic                  reg_low,
  output logic                  dbg_allowed
);

  logic dbg_nxt;
  logic in_stop;

  assign in_stop = (nxt_mode == MD_STOP);

  always_comb begin
    if (in_stop)               dbg_nxt = 1'b0;
    else if (is_wait(nxt_mode)) dbg_nxt = nxt_arm & ~secured & dbg_enable;
    else                       dbg_nxt = ~secured & dbg_enable;
  end

  generate
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_clk
      always_ff @(posedge clk) begin
        if (rst)          periph_clk_en[i] <= 1'b0;
        else if (in_stop) periph_clk_en[i] <= gate_mask[i] & ALWAYS_ON[i];
        else              periph_clk_en[i] <= gate_mask[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_status <= 3'd0;
      reg_low     <= 1'b0;
      dbg_allowed <= 1'b0;
    end else begin
      mode_status <= nxt_mode;
      reg_low     <= is_low_reg(nxt_mode) & ~nxt_exit;
      dbg_allowed <= dbg_nxt;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (mode_status == 3'd0 && periph_clk_en == '0 && !reg_low && !dbg_allowed)); // R11
  AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (rst)
    mode_status <= 3'd4); // R1
  AST_STOP_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd2) |-> ((periph_clk_en & ~ALWAYS_ON) == '0)); // R3
  AST_EXIT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd4 && !reg_low) |=> (mode_status == 3'd0)); // R8
  AST_VLPR_EXIT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd3 && !reg_low) |=> (mode_status == 3'd0)); // R10
  AST_STOP_NO_DEBUG: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd2) |-> !dbg_allowed); // R12

endmodule

// File: rtl/lpmc_top.sv
module lpmc_top
  import lpmc_pkg::*;
#(
  parameter int                    NUM_IRQ    = 8,
  parameter int                    NUM_PERIPH = 8,
  parameter logic [NUM_PERIPH-1:0] ALWAYS_ON  = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  stop_pulse,
  input  logic                  deep_sleep,
  input  logic                  vlp_request,
  input  logic                  wake_full,
  input  logic [NUM_IRQ-1:0]    irq_pending,
  input  logic [NUM_IRQ-1:0]    irq_enable,
  input  logic [NUM_PERIPH-1:0] gate_mask,
  input  logic                  secured,
  input  logic                  dbg_enable,
  input  logic                  dbg_arm,
  output logic [2:0]            mode_status,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic                  reg_low,
  output logic                  dbg_allowed
);

  logic  wake;
  mode_e nxt_mode;
  logic  nxt_exit;
  logic  nxt_arm;

  lpmc_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .wake        (wake)
  );

  lpmc_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .stop_pulse  (stop_pulse),
    .deep_sleep  (deep_sleep),
    .vlp_request (vlp_request),
    .wake_full   (wake_full),
    .wake        (wake),
    .secured     (secured),
    .dbg_enable  (dbg_enable),
    .dbg_arm     (dbg_arm),
    .nxt_mode    (nxt_mode),
    .nxt_exit    (nxt_exit),
    .nxt_arm     (nxt_arm)
  );

  lpmc_outreg #(.NUM_PERIPH(NUM_PERIPH), .ALWAYS_ON(ALWAYS_ON)) u_out (
    .clk           (clk),
    .rst           (rst),
    .nxt_mode      (nxt_mode),
    .nxt_exit      (nxt_exit),
    .nxt_arm       (nxt_arm),
    .gate_mask     (gate_mask),
    .secured       (secured),
    .dbg_enable    (dbg_enable),
    .mode_status   (mode_status),
    .periph_clk_en (periph_clk_en),
    .reg_low       (reg_low),
    .dbg_allowed   (dbg_allowed)
  );

endmodule

// File: tb/lpmc_top_test.sv
module lpmc_top_test;

  localparam int NI = 8;
  localparam int NP = 8;
  localparam logic [NP-1:0] AON = 8'h01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_pulse = 0, deep_sleep = 0, vlp_request = 0, wake_full = 0;
  logic [NI-1:0] irq_pending = '0, irq_enable = '0;
  logic [NP-1:0] gate_mask = '0;
  logic secured = 1'b1, dbg_enable = 1'b0, dbg_arm = 1'b0;
  logic [2:0] mode_status;
  logic [NP-1:0] periph_clk_en;
  logic reg_low, dbg_allowed;

  always #4 clk = ~clk;

  lpmc_top #(.NUM_IRQ(NI), .NUM_PERIPH(NP), .ALWAYS_ON(AON)) uut (
    .clk(clk), .rst(rst), .stop_pulse(stop_pulse), .deep_sleep(deep_sleep),
    .vlp_request(vlp_request), .wake_full(wake_full), .irq_pending(irq_pending),
    .irq_enable(irq_enable), .gate_mask(gate_mask), .secured(secured),
    .dbg_enable(dbg_enable), .dbg_arm(dbg_arm), .mode_status(mode_status),
    .periph_clk_en(periph_clk_en), .reg_low(reg_low), .dbg_allowed(dbg_allowed)
  );

  // behavioural reference model
  int m = 0;
  bit leaving = 0, armed = 0;
  int e_stat = 0;
  logic [NP-1:0] e_clk = '0;
  bit e_reg = 0, e_dbg = 0;

  always @(posedge clk) begin
    bit w;
    w = (irq_pending & irq_enable) != 0;
    if (rst) begin
      m = 0; leaving = 0; armed = 0;
    end else if (leaving) begin
      m = 0; leaving = 0;
    end else begin
      case (m)
        0: if (stop_pulse && !w) begin
             m = deep_sleep ? 2 : 1;
             armed = !secured && dbg_enable && dbg_arm;
           end else if (!stop_pulse && vlp_request) m = 3;
        3: if (stop_pulse && !w && !deep_sleep) begin
             m = 4;
             armed = !secured && dbg_enable && dbg_arm;
           end else if (!stop_pulse && !vlp_request) leaving = 1;
        1, 2: if (w) m = 0;
        4: if (w) begin
             if (wake_full) leaving = 1; else m = 3;
           end
        default: m = 0;
      endcase
    end
    if (rst) begin
      e_stat = 0; e_clk = '0; e_reg = 0; e_dbg = 0;
    end else begin
      e_stat = m;
      e_clk = (m == 2) ? (gate_mask & AON) : gate_mask;
      e_reg = (m == 3 || m == 4) && !leaving;
      if (m == 2) e_dbg = 0;
      else if (m == 1 || m == 4) e_dbg = armed && !secured && dbg_enable;
      else e_dbg = !secured && dbg_enable;
    end
  end

  int checks = 0, fails = 0;
  string tag = "R11";
  bit done = 0;

  task automatic compare();
    checks++;
    if (mode_status !== 3'(e_stat) || periph_clk_en !== e_clk ||
        reg_low !== e_reg || dbg_allowed !== e_dbg) begin
      fails++;
      $display("FAIL %s: status=%0d clk=%h reg=%b dbg=%b expected status=%0d clk=%h reg=%b dbg=%b",
               tag, mode_status, periph_clk_en, reg_low, dbg_allowed,
               e_stat, e_clk, e_reg, e_dbg);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      stop_pulse = 1'b0;
    end
  endtask

  task automatic expect_status(input int s, input string t);
    checks++;
    if (mode_status !== 3'(s)) begin
      fails++;
      $display("FAIL %s: status=%0d expected %0d", t, mode_status, s);
    end
  endtask

  task automatic stop_now(input bit deep);
    deep_sleep = deep; stop_pulse = 1'b1;
    cyc(1);
  endtask

  initial begin
    // R11 reset state
    tag = "R11"; cyc(3);
    expect_status(0, "R11");
    rst = 0; gate_mask = 8'hA5; secured = 0; dbg_enable = 1;
    tag = "R1"; cyc(3);
    tag = "R3"; gate_mask = 8'h3C; cyc(2);
    // R2 wait entry, R12 with arm set
    tag = "R2"; dbg_arm = 1; stop_now(0);
    expect_status(1, "R2");
    tag = "R12"; dbg_arm = 0; cyc(2);
    tag = "R4"; irq_pending = 8'h10; irq_enable = 8'h01; cyc(3);
    expect_status(1, "R4");
    irq_enable = 8'h10; cyc(1);
    expect_status(0, "R4");
    irq_pending = '0; cyc(1);
    // stop entry, clocks gated
    tag = "R3"; gate_mask = 8'hFF; stop_now(1);
    expect_status(2, "R2");
    cyc(3);
    tag = "R4"; irq_pending = 8'h10; cyc(1); irq_pending = '0; cyc(1);
    // wait entry without arm: debug blocked
    tag = "R12"; stop_now(0); cyc(2);
    irq_pending = 8'h10; cyc(1); irq_pending = '0; cyc(1);
    // R5 stop with simultaneous interrupt
    tag = "R5"; irq_pending = 8'h10; stop_now(1);
    expect_status(0, "R5");
    irq_pending = '0; cyc(2);
    // R6 enter VLPR
    tag = "R6"; vlp_request = 1; cyc(2);
    expect_status(3, "R6");
    tag = "R7"; stop_now(1); cyc(1);
    expect_status(3, "R7");
    dbg_arm = 1; stop_now(0); dbg_arm = 0;
    expect_status(4, "R7");
    cyc(2);
    tag = "R9"; wake_full = 0; irq_pending = 8'h10; cyc(1);
    expect_status(3, "R9");
    irq_pending = '0; cyc(1);
    tag = "R8"; stop_now(0); cyc(1);
    wake_full = 1; vlp_request = 0; irq_pending = 8'h10; cyc(1);
    expect_status(4, "R8");
    irq_pending = '0; cyc(1);
    expect_status(0, "R8");
    // R10 leave VLPR by dropping request
    tag = "R10"; vlp_request = 1; cyc(2); vlp_request = 0; cyc(1);
    expect_status(3, "R10");
    cyc(1);
    expect_status(0, "R10");
    // R11 reset from wait
    tag = "R11"; stop_now(0); cyc(1); rst = 1; cyc(1);
    expect_status(0, "R11");
    rst = 0; cyc(2);
    // randomised mode sequences
    tag = "R1";
    for (int k = 0; k < 4000; k++) begin
      stop_pulse  = ($urandom_range(0, 5) == 0);
      deep_sleep  = $urandom_range(0, 1);
      vlp_request = ($urandom_range(0, 3) != 0);
      wake_full   = $urandom_range(0, 1);
      irq_pending = ($urandom_range(0, 6) == 0) ? 8'($urandom) : '0;
      irq_enable  = 8'($urandom);
      gate_mask   = 8'($urandom);
      secured     = ($urandom_range(0, 4) == 0);
      dbg_enable  = ($urandom_range(0, 4) != 0);
      dbg_arm     = $urandom_range(0, 1);
      rst         = ($urandom_range(0, 300) == 0);
      cyc(1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule